// File: doc/BRIEF.md
# Recalibration Command Sequencer

This block is an AXI4-Lite master that runs one memory recalibration and reports its outcome. A one-cycle `start` pulse, with a channel select and an instance number, launches a fixed handshake. The block writes a command word to the command request register. It then polls the response status register until its ready flag is set. Next it clears that flag by writing back the value it read with bit 0 forced low. Last, it polls the calibration status register until a success or failure bit appears.

Each polling loop is limited to a programmable number of reads. When that limit runs out, the block gives a timeout instead of a calibration result. Any slave error response stops the sequence at once. When the sequence ends, `done` pulses for one cycle. Exactly one of four outcome flags is then set, and it stays set until the next accepted start.

Top module: `recal_seq`

## Requirements
- R1: The first transaction after an accepted start is a write to BASE_ADDR+CMD_OFS with all byte strobes set. Its data is {type[2:0], instance[4:0], 8'h05, 16'h000A}, where type is 3'd1 when `chanSel`=0 and 3'd2 when `chanSel`=1, and instance is `instId`. No other write comes before it.
- R2: After the command write, the block reads BASE_ADDR+RSP_OFS again and again until a read returns bit 0 = 1.
- R3: The ready flag is cleared by writing to BASE_ADDR+RSP_OFS the value returned by the read that saw bit 0 = 1, with bit 0 forced to 0 and all other bits unchanged.
- R4: After the clear, the block reads BASE_ADDR+STAT_OFS again and again until bit 0 (success) or bit 1 (failure) reads 1. Bit 0 alone ends with `calPass`=1.
- R5: A status read with bit 1 = 1 ends with `calFail`=1, whether or not bit 0 is also set. Status values with neither bit set (for example 32'h4) keep the block polling.
- R6: Each polling loop performs at most `pollMax` reads (a value of 0 counts as 1). A condition seen on exactly the `pollMax`-th read still succeeds. If the `pollMax`-th read misses the condition, the block ends with `timeout`=1, does not set `calPass` or `calFail`, and issues no further transaction.
- R7: A non-zero BRESP or RRESP on any transaction ends the sequence with `slvErr`=1, and no further transaction is issued.
- R8: `start` is ignored while `busy` is 1. `done` is a pulse one cycle wide. The outcome flags hold their values after `done` until the next accepted start, which clears them.
- R9: Once a valid is raised on AW, W or AR, it stays high until its ready is seen. BREADY and RREADY are high only while a response is awaited.
- R10: After reset, all valid outputs, `busy`, `done` and all outcome flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| chanSel | input | 1 | Channel select: 0 gives type 1, 1 gives type 2 |
| instId | input | 5 | Target instance number placed in the command word |
| pollMax | input | CNT_W | Maximum number of reads in each polling loop |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| calPass | output | 1 | Calibration reported success |
| calFail | output | 1 | Calibration reported failure |
| timeout | output | 1 | A polling loop ran out of reads |
| slvErr | output | 1 | A slave error response aborted the sequence |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | ADDR_W | Write address |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | 32 | Write data |
| wstrb | output | 4 | Write strobes, always all ones |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| bresp | input | 2 | Write response code |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | ADDR_W | Read address |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | 32 | Read data |
| rresp | input | 2 | Read response code |

## Verification
The bench places the success point exactly on the last permitted read. A poll counter that is off by one would report a timeout there, or would allow one read too many in the timeout tests. It returns status words with both bits set, which catches a decoder that lets success take priority. It uses a response word with many high bits set, so a clear that writes a constant or drops the mask shows up in the logged write data. It also injects slave errors on both the command write and a poll read, and pulses start in the middle of a run. A block that ignores errors would keep issuing transactions, and one that re-arms on start would log a second command or a second done.

// File: rtl/recal_pkg.sv
package recal_pkg;

  localparam int DATA_W = 32;
  localparam logic [7:0]  CMD_KIND   = 8'h05;
  localparam logic [15:0] CMD_RECAL  = 16'h000A;

  typedef enum logic [2:0] {
    S_IDLE, S_WR, S_WB, S_RA, S_RD, S_DONE
  } seqState_e;

  typedef enum logic [1:0] {
    PH_CMD, PH_RSP, PH_CLR, PH_STA
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrRes;
    logic ldCmd;
    logic ldClr;
    logic cntClr;
    logic cntInc;
    logic setPass;
    logic setFail;
    logic setTo;
    logic setErr;
    logic wrSelClr;
    logic rdSelSta;
  } dpCtl_t;

endpackage

// File: rtl/recal_dp.sv
module recal_dp
  import recal_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          CNT_W     = 16,
  parameter logic [31:0] BASE_ADDR = 32'h0,
  parameter logic [31:0] CMD_OFS   = 32'h43C,
  parameter logic [31:0] RSP_OFS   = 32'h45C,
  parameter logic [31:0] STAT_OFS  = 32'h400
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              chanSel,
  input  logic [4:0]        instId,
  input  logic [CNT_W-1:0]  pollMax,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] awaddr,
  output logic [ADDR_W-1:0] araddr,
  output logic [DATA_W-1:0] wdata,
  output logic              pollLast,
  output logic              calPass,
  output logic              calFail,
  output logic              timeout,
  output logic              slvErr
);

  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(BASE_ADDR + CMD_OFS);
  localparam logic [ADDR_W-1:0] RSP_ADDR = ADDR_W'(BASE_ADDR + RSP_OFS);
  localparam logic [ADDR_W-1:0] STA_ADDR = ADDR_W'(BASE_ADDR + STAT_OFS);

  logic [CNT_W-1:0] pollCnt;
  logic [CNT_W:0]   pollNext;
  logic [2:0]       tgtType;

  assign tgtType  = chanSel ? 3'd2 : 3'd1;
  assign pollNext = {1'b0, pollCnt} + 1'b1;
  assign pollLast = pollNext >= {1'b0, pollMax};

  assign awaddr = ctl.wrSelClr ? RSP_ADDR : CMD_ADDR;
  assign araddr = ctl.rdSelSta ? STA_ADDR : RSP_ADDR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdata   <= '0;
      pollCnt <= '0;
    end else begin
      if (ctl.ldCmd)      wdata <= {tgtType, instId, CMD_KIND, CMD_RECAL};
      else if (ctl.ldClr) wdata <= rdata & ~DATA_W'(1);
      if (ctl.cntClr)      pollCnt <= '0;
      else if (ctl.cntInc) pollCnt <= pollCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrRes) begin
      calPass <= 1'b0;
      calFail <= 1'b0;
      timeout <= 1'b0;
      slvErr  <= 1'b0;
    end else begin
      if (ctl.setPass) calPass <= 1'b1;
      if (ctl.setFail) calFail <= 1'b1;
      if (ctl.setTo)   timeout <= 1'b1;
      if (ctl.setErr)  slvErr  <= 1'b1;
    end
  end

  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({calPass, calFail, timeout, slvErr}));

  p_cmd_word_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.ldCmd) |-> wdata[23:0] == {CMD_KIND, CMD_RECAL});

  p_clr_bit0_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.ldClr) |-> !wdata[0]);

endmodule

// File: rtl/recal_ctrl.sv
module recal_ctrl
  import recal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       awready,
  input  logic       wready,
  input  logic       bvalid,
  input  logic [1:0] bresp,
  input  logic       arready,
  input  logic       rvalid,
  input  logic [1:0] rresp,
  input  logic [1:0] rdLow,
  input  logic       pollLast,
  output logic       awvalid,
  output logic       wvalid,
  output logic       bready,
  output logic       arvalid,
  output logic       rready,
  output logic       busy,
  output logic       done,
  output dpCtl_t     ctl
);

  seqState_e state, stateNxt;
  phase_e    phase, phaseNxt;
  logic      awDone, wDone, awFin, wFin;

  assign awvalid = (state == S_WR) && !awDone;
  assign wvalid  = (state == S_WR) && !wDone;
  assign bready  = (state == S_WB);
  assign arvalid = (state == S_RA);
  assign rready  = (state == S_RD);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_DONE);

  assign awFin = awDone || (awvalid && awready);
  assign wFin  = wDone  || (wvalid && wready);

  always_comb begin
    stateNxt     = state;
    phaseNxt     = phase;
    ctl          = '0;
    ctl.wrSelClr = (phase == PH_CLR);
    ctl.rdSelSta = (phase == PH_STA);
    case (state)
      S_IDLE: if (start) begin
        ctl.clrRes = 1'b1;
        ctl.ldCmd  = 1'b1;
        phaseNxt   = PH_CMD;
        stateNxt   = S_WR;
      end
      S_WR: if (awFin && wFin) stateNxt = S_WB;
      S_WB: if (bvalid) begin
        if (bresp != 2'b00) begin
          ctl.setErr = 1'b1;
          stateNxt   = S_DONE;
        end else begin
          ctl.cntClr = 1'b1;
          phaseNxt   = (phase == PH_CMD) ? PH_RSP : PH_STA;
          stateNxt   = S_RA;
        end
      end
      S_RA: if (arready) stateNxt = S_RD;
      S_RD: if (rvalid) begin
        if (rresp != 2'b00) begin
          ctl.setErr = 1'b1;
          stateNxt   = S_DONE;
        end else if (phase == PH_RSP) begin
          if (rdLow[0]) begin
            ctl.ldClr = 1'b1;
            phaseNxt  = PH_CLR;
            stateNxt  = S_WR;
          end else if (pollLast) begin
            ctl.setTo = 1'b1;
            stateNxt  = S_DONE;
          end else begin
            ctl.cntInc = 1'b1;
            stateNxt   = S_RA;
          end
        end else begin
          if (rdLow[1]) begin          // failure wins over success
            ctl.setFail = 1'b1;
            stateNxt    = S_DONE;
          end else if (rdLow[0]) begin
            ctl.setPass = 1'b1;
            stateNxt    = S_DONE;
          end else if (pollLast) begin
            ctl.setTo = 1'b1;
            stateNxt  = S_DONE;
          end else begin
            ctl.cntInc = 1'b1;
            stateNxt   = S_RA;
          end
        end
      end
      S_DONE:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      phase  <= PH_CMD;
      awDone <= 1'b0;
      wDone  <= 1'b0;
    end else begin
      state <= stateNxt;
      phase <= phaseNxt;
      if (state != S_WR) begin
        awDone <= 1'b0;
        wDone  <= 1'b0;
      end else begin
        awDone <= awFin;
        wDone  <= wFin;
      end
    end
  end

  p_aw_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    awvalid && !awready |=> awvalid);
  p_w_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    wvalid && !wready |=> wvalid);
  p_ar_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    arvalid && !arready |=> arvalid);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/recal_seq.sv
module recal_seq
  import recal_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          CNT_W     = 16,
  parameter logic [31:0] BASE_ADDR = 32'h0,
  parameter logic [31:0] CMD_OFS   = 32'h43C,
  parameter logic [31:0] RSP_OFS   = 32'h45C,
  parameter logic [31:0] STAT_OFS  = 32'h400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              chanSel,
  input  logic [4:0]        instId,
  input  logic [CNT_W-1:0]  pollMax,
  output logic              busy,
  output logic              done,
  output logic              calPass,
  output logic              calFail,
  output logic              timeout,
  output logic              slvErr,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic              wvalid,
  input  logic              wready,
  output logic [31:0]       wdata,
  output logic [3:0]        wstrb,
  input  logic              bvalid,
  output logic              bready,
  input  logic [1:0]        bresp,
  output logic              arvalid,
  input  logic              arready,
  output logic [ADDR_W-1:0] araddr,
  input  logic              rvalid,
  output logic              rready,
  input  logic [31:0]       rdata,
  input  logic [1:0]        rresp
);

  dpCtl_t ctl;
  logic   pollLast;

  assign wstrb = 4'hF;

  recal_ctrl i_ctrl (
    .clk, .rstN, .start, .awready, .wready, .bvalid, .bresp,
    .arready, .rvalid, .rresp, .rdLow(rdata[1:0]), .pollLast,
    .awvalid, .wvalid, .bready, .arvalid, .rready, .busy, .done, .ctl
  );

  recal_dp #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BASE_ADDR(BASE_ADDR),
    .CMD_OFS(CMD_OFS), .RSP_OFS(RSP_OFS), .STAT_OFS(STAT_OFS)
  ) i_dp (
    .clk, .rstN, .ctl, .chanSel, .instId, .pollMax, .rdata,
    .awaddr, .araddr, .wdata, .pollLast,
    .calPass, .calFail, .timeout, .slvErr
  );

endmodule

// File: tb/test_recal_seq.sv
module test_recal_seq;

  localparam logic [31:0] BASE  = 32'h0010_0000;
  localparam logic [31:0] A_CMD = BASE + 32'h43C;
  localparam logic [31:0] A_RSP = BASE + 32'h45C;
  localparam logic [31:0] A_STA = BASE + 32'h400;
  localparam logic [31:0] RSP_HI = 32'hC3C3_00F1;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, chanSel = 1'b0;
  logic [4:0] instId = '0;
  logic [15:0] pollMax = 16'd8;
  logic busy, done, calPass, calFail, timeout, slvErr;
  logic awvalid, awready, wvalid, wready, bvalid, bready, arvalid, arready, rvalid, rready;
  logic [31:0] awaddr, araddr, wdata, rdata;
  logic [3:0]  wstrb;
  logic [1:0]  bresp, rresp;

  always #4 clk = ~clk;

  recal_seq #(.BASE_ADDR(BASE)) i_recal_seq (
    .clk, .rstN, .start, .chanSel, .instId, .pollMax, .busy, .done,
    .calPass, .calFail, .timeout, .slvErr,
    .awvalid, .awready, .awaddr, .wvalid, .wready, .wdata, .wstrb,
    .bvalid, .bready, .bresp, .arvalid, .arready, .araddr,
    .rvalid, .rready, .rdata, .rresp
  );

  // slave model configuration
  int rspAt = 1, staAt = 1, errAt = -1;
  logic [31:0] staVal = 32'h1;

  // slave model state and log
  int txnIdx, wrCount, rspReads, staReads, doneCnt;
  logic gotAw, gotW;
  logic [31:0] lastA, lastD;
  logic [31:0] logA [8];
  logic [31:0] logD [8];
  logic [3:0]  logS [8];

  always @(posedge clk) begin
    if (!rstN) begin
      awready <= 0; wready <= 0; arready <= 0; bvalid <= 0; rvalid <= 0;
      bresp <= 0; rresp <= 0; rdata <= 0; gotAw <= 0; gotW <= 0;
      txnIdx <= 0; wrCount <= 0; rspReads <= 0; staReads <= 0; doneCnt <= 0;
    end else begin
      if (done) doneCnt <= doneCnt + 1;
      if (start && !busy) begin
        txnIdx <= 0; wrCount <= 0; rspReads <= 0; staReads <= 0;
      end
      awready <= awvalid && !awready && !gotAw;
      wready  <= wvalid && !wready && !gotW;
      if (awvalid && awready) begin gotAw <= 1; lastA <= awaddr; end
      if (wvalid && wready) begin gotW <= 1; lastD <= wdata; logS[wrCount & 7] <= wstrb; end
      if (gotAw && gotW && !bvalid) begin
        bvalid <= 1;
        bresp  <= (txnIdx == errAt) ? 2'b10 : 2'b00;
        logA[wrCount & 7] <= lastA;
        logD[wrCount & 7] <= lastD;
        wrCount <= wrCount + 1;
        txnIdx  <= txnIdx + 1;
        gotAw <= 0; gotW <= 0;
      end
      if (bvalid && bready) bvalid <= 0;
      arready <= arvalid && !arready && !rvalid;
      if (arvalid && arready) begin
        rvalid <= 1;
        rresp  <= (txnIdx == errAt) ? 2'b10 : 2'b00;
        txnIdx <= txnIdx + 1;
        if (araddr == A_RSP) begin
          rdata <= (rspReads + 1 >= rspAt) ? RSP_HI : (RSP_HI & ~32'h1);
          rspReads <= rspReads + 1;
        end else begin
          rdata <= (staReads + 1 >= staAt) ? staVal : 32'h4;
          staReads <= staReads + 1;
        end
      end
      if (rvalid && rready) rvalid <= 0;
    end
  end

  int testCnt = 0, failCnt = 0, cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      failCnt = failCnt + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart(input logic ch, input logic [4:0] inst, input logic [15:0] pm);
    @(negedge clk);
    chanSel = ch; instId = inst; pollMax = pm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(req, "done reached", {31'b0, done}, 32'h1);
  endtask

  task automatic outcome(input string req, input logic [3:0] exp);
    chk(req, "outcome {pass,fail,to,err}", {28'b0, calPass, calFail, timeout, slvErr}, {28'b0, exp});
  endtask

  task automatic t_reset;
    chk("R10", "idle outputs", {24'b0, awvalid, wvalid, arvalid, busy, done, calPass, calFail, timeout}, 32'h0);
    chk("R10", "slvErr", {31'b0, slvErr}, 32'h0);
  endtask

  task automatic t_pass_ch0;
    rspAt = 3; staAt = 2; staVal = 32'h1; errAt = -1;
    pulseStart(1'b0, 5'd0, 16'd3);
    waitDone("R4");
    outcome("R4", 4'b1000);
    chk("R1", "cmd addr", logA[0], A_CMD);
    chk("R1", "cmd data ch0", logD[0], 32'h2005_000A);
    chk("R1", "cmd strobes", {28'b0, logS[0]}, 32'hF);
    chk("R2", "rsp reads", rspReads, 3);
    chk("R6", "success on last permitted read, no timeout", {31'b0, timeout}, 32'h0);
    chk("R3", "clear addr", logA[1], A_RSP);
    chk("R3", "clear data", logD[1], RSP_HI & ~32'h1);
    chk("R4", "status reads", staReads, 2);
    chk("R4", "write count", wrCount, 2);
  endtask

  task automatic t_fail_ch1;
    rspAt = 1; staAt = 3; staVal = 32'h2; errAt = -1;
    pulseStart(1'b1, 5'd3, 16'd8);
    waitDone("R5");
    outcome("R5", 4'b0100);
    chk("R1", "cmd data ch1 inst3", logD[0], 32'h4305_000A);
  endtask

  task automatic t_both_bits;
    rspAt = 2; staAt = 1; staVal = 32'h3; errAt = -1;
    pulseStart(1'b0, 5'd0, 16'd8);
    waitDone("R5");
    outcome("R5", 4'b0100);
  endtask

  task automatic t_timeout_rsp;
    rspAt = 100; staAt = 1; staVal = 32'h1; errAt = -1;
    pulseStart(1'b0, 5'd0, 16'd4);
    waitDone("R6");
    outcome("R6", 4'b0010);
    chk("R6", "rsp reads at limit", rspReads, 4);
    chk("R6", "no clear write", wrCount, 1);
    chk("R6", "no status read", staReads, 0);
  endtask

  task automatic t_timeout_sta;
    rspAt = 1; staAt = 50; staVal = 32'h1; errAt = -1;
    pulseStart(1'b0, 5'd0, 16'd3);
    waitDone("R6");
    outcome("R6", 4'b0010);
    chk("R6", "status reads at limit", staReads, 3);
  endtask

  task automatic t_err_write;
    rspAt = 1; staAt = 1; staVal = 32'h1; errAt = 0;
    pulseStart(1'b0, 5'd0, 16'd8);
    waitDone("R7");
    outcome("R7", 4'b0001);
    repeat (5) @(negedge clk);
    chk("R7", "no read after write error", rspReads + staReads, 0);
  endtask

  task automatic t_err_read;
    rspAt = 1; staAt = 1; staVal = 32'h1; errAt = 1;
    pulseStart(1'b0, 5'd0, 16'd8);
    waitDone("R7");
    outcome("R7", 4'b0001);
    repeat (5) @(negedge clk);
    chk("R7", "no clear after read error", wrCount, 1);
  endtask

  task automatic t_busy_start;
    int d0;
    rspAt = 2; staAt = 2; staVal = 32'h1; errAt = -1;
    d0 = doneCnt;
    pulseStart(1'b0, 5'd0, 16'd8);
    repeat (3) @(negedge clk);
    chanSel = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone("R8");
    repeat (10) @(negedge clk);
    chk("R8", "single done pulse", doneCnt - d0, 1);
    chk("R8", "single cmd word", logD[0], 32'h2005_000A);
    chk("R8", "write count", wrCount, 2);
    chk("R8", "outcome held, done low", {30'b0, calPass, done}, 32'h2);
    pulseStart(1'b0, 5'd0, 16'd8);
    chk("R8", "outcome cleared on start", {30'b0, busy, calPass}, 32'h2);
    waitDone("R8");
    outcome("R8", 4'b1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_pass_ch0();
    t_fail_ch1();
    t_both_bits();
    t_timeout_rsp();
    t_timeout_sta();
    t_err_write();
    t_err_read();
    t_busy_start();
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule